// File: doc/BRIEF.md
# 1-Wire ROM Identification Responder

This block is the slave side of a single-wire, open-drain bus. It holds a 64-bit identification code and lets a bus master read it out. A long low on the line resets the responder, and it answers with a presence pulse. It then takes an 8-bit command, one write slot per bit. Two commands are served. The read command sends the whole code, one bit per read slot. The search command takes part in the true/complement/select triplets that a master uses to walk the code tree when several slaves share the line.

All timing is counted in microseconds from a one-cycle `us_tick_i` strobe. The line input is expected already synchronised to `clk_i`. `pull_o` is the pull-down enable of an external open-drain driver. When `pull_o` is high the line is low. Any other command, a lost search, or the end of a transfer makes the responder silent until the next bus reset.

Top module: `ow_rom_responder`

## Requirements
- R1: When the line rises after a low of at least RST_MIN_US, `pull_o` rises PD_WAIT_US later (15 to 60 us) and stays high for PD_LEN_US (60 to 240 us).
- R2: Before the first valid bus reset, `pull_o` stays low. Slots and lows shorter than RST_MIN_US are ignored and give no presence pulse.
- R3: Command bits arrive least significant bit first. Each bit is sampled SLOT_US after the falling edge: a low line is 0 and a high line is 1.
- R4: Command 33h (read) makes the next 64 read slots carry `rom_code_i[0]` to `rom_code_i[63]` in that order. The layout is family code in bits 7:0, serial number in bits 55:8 and check byte in bits 63:56.
- R5: In a read slot, a 0 is sent by holding `pull_o` high from just after the master's falling edge until SLOT_US after that edge. A 1 is sent by leaving `pull_o` low.
- R6: Command F0h (search) handles each code bit, starting at bit 0, as three slots. The first slot sends the true bit, the second sends its complement, and the third samples the master's selected bit. A match moves on to the next bit.
- R7: If the selected bit in a search does not equal the code bit, the responder sends nothing more until the next bus reset.
- R8: Any command other than 33h or F0h (for example 55h or CCh) leaves the responder silent until the next bus reset.
- R9: After all 64 bits of a read or a search, the responder is silent until the next bus reset.
- R10: A low of RST_MIN_US or more in any state aborts the transfer in progress and restarts the presence sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle strobe once per microsecond |
| line_i | input | 1 | Synchronised level of the bus line |
| rom_code_i | input | 64 | Identification code, bit 0 sent first |
| pull_o | output | 1 | Pull-down enable for the open-drain driver |

## Verification
The read command is tried with two unlike codes. Each one has mixed runs of zeros and ones, so a reversed bit order, a wrong field placement or an inverted read level shows up at a named slot. The search command is first walked to the end with matching selections, which checks the true and complement slots of every bit. It is then run again with a wrong selection at bit 5. That second run separates "stop taking part" from "keep answering" and from "answer the wrong bit". Short lows in the unreset state, two unsupported commands, and a reset in the middle of a read cover the silence and abort paths.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PD_WAIT, ST_PD_DRIVE, ST_CMD, ST_READ, ST_SEARCH, ST_MUTE
  } ow_state_e;

  typedef enum logic [1:0] {OP_READ, OP_SEARCH, OP_NONE} ow_op_e;

  localparam logic [7:0] OP_CODE_READ   = 8'h33;
  localparam logic [7:0] OP_CODE_SEARCH = 8'hF0;
endpackage

// File: rtl/ow_line_timer.sv
module ow_line_timer #(
  parameter int RST_MIN_US = 480,
  parameter int TW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          us_tick_i,
  input  logic          line_i,
  input  logic          clr_i,
  output logic          fall_o,
  output logic          bus_rst_o,
  output logic [TW-1:0] tim_o
);
  localparam int LW = $clog2(RST_MIN_US + 1);

  logic          line_q;
  logic [LW-1:0] low_q;
  logic [TW-1:0] tim_q;

  assign fall_o    = line_q & ~line_i;
  assign bus_rst_o = ~line_q & line_i & (low_q >= LW'(RST_MIN_US));
  assign tim_o     = tim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      low_q  <= '0;
      tim_q  <= '0;
    end else begin
      line_q <= line_i;
      // low length, saturates at the reset threshold
      if (fall_o) low_q <= '0;
      else if (!line_q && us_tick_i && low_q < LW'(RST_MIN_US)) low_q <= low_q + 1'b1;
      // phase timer: microseconds since last fall or explicit clear
      if (fall_o || clr_i) tim_q <= '0;
      else if (us_tick_i && tim_q != '1) tim_q <= tim_q + 1'b1;
    end
  end
endmodule

// File: rtl/ow_cmd_decode.sv
module ow_cmd_decode
  import ow_pkg::*;
(
  input  logic [7:0] byte_i,
  output ow_op_e     op_o
);
  always_comb begin
    case (byte_i)
      OP_CODE_READ:   op_o = OP_READ;
      OP_CODE_SEARCH: op_o = OP_SEARCH;
      default:        op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/ow_rom_responder.sv
module ow_rom_responder
  import ow_pkg::*;
#(
  parameter int ID_BITS    = 64,
  parameter int RST_MIN_US = 480,
  parameter int PD_WAIT_US = 30,
  parameter int PD_LEN_US  = 120,
  parameter int SLOT_US    = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               us_tick_i,
  input  logic               line_i,
  input  logic [ID_BITS-1:0] rom_code_i,
  output logic               pull_o
);
  localparam int BW = $clog2(ID_BITS);
  localparam int TW = $clog2(PD_WAIT_US + PD_LEN_US + SLOT_US + 2);
  localparam logic [BW-1:0] LAST_BIT = BW'(ID_BITS - 1);

  ow_state_e     st_q;
  logic          pull_q, slot_q;
  logic [BW-1:0] bit_q;
  logic [7:0]    cmd_q;
  logic [2:0]    cnt_q;
  logic [1:0]    ph_q;

  logic          fall, rst_det, clr;
  logic [TW-1:0] tim;
  logic [7:0]    cmd_next;
  ow_op_e        op;
  logic          code_bit, wait_hit, len_hit, slot_hit;

  assign wait_hit = us_tick_i && tim == TW'(PD_WAIT_US - 1);
  assign len_hit  = us_tick_i && tim == TW'(PD_LEN_US - 1);
  assign slot_hit = slot_q && us_tick_i && tim == TW'(SLOT_US - 1);
  assign clr      = rst_det || (st_q == ST_PD_WAIT && wait_hit);
  assign cmd_next = {line_i, cmd_q[7:1]};
  assign code_bit = rom_code_i[bit_q];
  assign pull_o   = pull_q;

  ow_line_timer #(.RST_MIN_US(RST_MIN_US), .TW(TW)) u_timer (
    .clk_i, .rst_ni, .us_tick_i, .line_i,
    .clr_i(clr), .fall_o(fall), .bus_rst_o(rst_det), .tim_o(tim)
  );

  ow_cmd_decode u_dec (.byte_i(cmd_next), .op_o(op));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
      slot_q <= 1'b0;
      bit_q  <= '0;
      cmd_q  <= '0;
      cnt_q  <= '0;
      ph_q   <= '0;
    end else if (rst_det) begin
      st_q   <= ST_PD_WAIT;
      pull_q <= 1'b0;
      slot_q <= 1'b0;
      bit_q  <= '0;
      cnt_q  <= '0;
      ph_q   <= '0;
    end else begin
      case (st_q)
        ST_PD_WAIT: if (wait_hit) begin
          st_q   <= ST_PD_DRIVE;
          pull_q <= 1'b1;
        end
        ST_PD_DRIVE: if (len_hit) begin
          st_q   <= ST_CMD;
          pull_q <= 1'b0;
        end
        ST_CMD: begin
          if (fall) slot_q <= 1'b1;
          else if (slot_hit) begin
            slot_q <= 1'b0;
            cmd_q  <= cmd_next;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == 3'd7) begin
              case (op)
                OP_READ:   st_q <= ST_READ;
                OP_SEARCH: st_q <= ST_SEARCH;
                default:   st_q <= ST_MUTE;
              endcase
            end
          end
        end
        ST_READ: begin
          if (fall) begin
            slot_q <= 1'b1;
            pull_q <= ~code_bit;
          end else if (slot_hit) begin
            slot_q <= 1'b0;
            pull_q <= 1'b0;
            bit_q  <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) st_q <= ST_MUTE;
          end
        end
        ST_SEARCH: begin
          if (fall) begin
            slot_q <= 1'b1;
            case (ph_q)
              2'd0:    pull_q <= ~code_bit;
              2'd1:    pull_q <= code_bit;
              default: pull_q <= 1'b0;
            endcase
          end else if (slot_hit) begin
            slot_q <= 1'b0;
            pull_q <= 1'b0;
            if (ph_q == 2'd2) begin
              ph_q <= '0;
              if (line_i != code_bit || bit_q == LAST_BIT) st_q <= ST_MUTE;
              else bit_q <= bit_q + 1'b1;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ow_rom_responder_chk.sv
module ow_rom_responder_chk
  import ow_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      line_i,
  input logic      pull_o,
  input ow_state_e st_i,
  input logic      rst_det_i
);
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_IDLE |-> !pull_o); // R2
  AST_PD_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_o) && st_i == ST_PD_DRIVE) |-> $past(st_i) == ST_PD_WAIT); // R1
  AST_PULL_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_o) && (st_i == ST_READ || st_i == ST_SEARCH)) |-> $past(!line_i)); // R5
  AST_MUTE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_MUTE |-> !pull_o); // R8
  AST_RESET_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_det_i |=> (st_i == ST_PD_WAIT && !pull_o)); // R10
endmodule

bind ow_rom_responder ow_rom_responder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .pull_o(pull_o),
  .st_i(st_q), .rst_det_i(rst_det)
);

// File: tb/ow_rom_responder_bench.sv
module ow_rom_responder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        m_low = 1'b0;
  logic        line;
  logic        pull;
  logic [63:0] code;
  int          checks = 0;
  int          fails = 0;

  localparam logic [63:0] CODE_A = 64'hA5_0123456789AB_01;
  localparam logic [63:0] CODE_B = 64'h3C_F0E1D2C3B4A5_96;

  always #2.5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;   // one microsecond every two cycles
  assign line = ~(m_low | pull);

  ow_rom_responder u_ow_rom_responder (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .line_i(line),
    .rom_code_i(code), .pull_o(pull)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  // master low of low_us, then watch for presence for 300 us
  task automatic bus_reset(input int low_us, output int start_us, output int len_us);
    int first = -1;
    int len = 0;
    m_low = 1'b1;
    wait_us(low_us);
    m_low = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (pull) begin
        if (first < 0) first = i;
        len++;
      end
    end
    start_us = first < 0 ? -1 : first / 2;
    len_us = len / 2;
  endtask

  task automatic write_bit(input bit b);
    m_low = 1'b1;
    wait_us(b ? 3 : 60);
    m_low = 1'b0;
    wait_us(b ? 62 : 5);
  endtask

  task automatic read_bit(output bit b);
    m_low = 1'b1;
    wait_us(2);
    m_low = 1'b0;
    wait_us(13);
    b = line;
    wait_us(50);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) write_bit(v[i]);
  endtask

  task automatic expect_presence(input string tag);
    int s, l;
    bus_reset(500, s, l);
    chk(s >= 15 && s <= 60, tag, s, PD_MID);
    chk(l >= 60 && l <= 240, tag, l, PD_LEN);
  endtask
  localparam int PD_MID = 30;
  localparam int PD_LEN = 120;

  task automatic read_rom(input logic [63:0] c, input int nbits);
    bit b;
    for (int i = 0; i < nbits; i++) begin
      read_bit(b);
      chk(b == c[i], "R4 R5 read slot", b, c[i]);
    end
  endtask

  task automatic expect_silent(input int n, input string tag);
    bit b;
    for (int i = 0; i < n; i++) begin
      read_bit(b);
      chk(b == 1'b1, tag, b, 1);
    end
  endtask

  initial begin
    int s, l;
    bit t, cb;
    code = CODE_A;
    repeat (5) @(negedge clk);
    chk(pull == 1'b0, "R2 pull low in reset", pull, 0);
    rst_n = 1'b1;
    wait_us(20);

    // R2: traffic before any bus reset is ignored
    write_byte(8'h33);
    expect_silent(4, "R2 idle read slot");
    bus_reset(200, s, l);
    chk(s == -1, "R2 short low no presence", s, -1);

    // R1, R3, R4: read with code A
    expect_presence("R1 presence");
    write_byte(8'h33);
    read_rom(CODE_A, 64);
    expect_silent(3, "R9 after read");

    // R4 with code B
    code = CODE_B;
    expect_presence("R1 presence B");
    write_byte(8'h33);
    read_rom(CODE_B, 64);

    // R6: full search with matching selections
    expect_presence("R1 presence search");
    write_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      read_bit(t);
      read_bit(cb);
      chk(t == code[i], "R6 true bit", t, code[i]);
      chk(cb == ~code[i], "R6 complement bit", cb, ~code[i]);
      write_bit(code[i]);
    end
    expect_silent(2, "R9 after search");

    // R7: lose the search at bit 5
    expect_presence("R1 presence lost search");
    write_byte(8'hF0);
    for (int i = 0; i < 6; i++) begin
      read_bit(t);
      read_bit(cb);
      chk(t == code[i] && cb == ~code[i], "R6 triplet", {t, cb}, {code[i], ~code[i]});
      write_bit(i == 5 ? ~code[i] : code[i]);
    end
    expect_silent(6, "R7 after mismatch");

    // R8: unsupported commands
    expect_presence("R1 presence 55h");
    write_byte(8'h55);
    expect_silent(4, "R8 after 55h");
    expect_presence("R1 presence CCh");
    write_byte(8'hCC);
    expect_silent(4, "R8 after CCh");

    // R10: reset in the middle of a read
    expect_presence("R1 presence abort");
    write_byte(8'h33);
    read_rom(CODE_B, 10);
    expect_presence("R10 presence after abort");
    write_byte(8'h33);
    read_rom(CODE_B, 64);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule